// File: doc/BRIEF.md
# Zero-Overhead Hardware Loop Controller

This block lets a processor repeat a short stretch of code without executing a branch or a counter update in software. It holds two loop contexts. Each context has a first-instruction address, a last-instruction address and a remaining-iteration count. The controller compares the address of the instruction being issued with the last-instruction address of every active context. When the address matches and more iterations remain, it raises a redirect request toward fetch in the same cycle, so the return to the top of the body costs no stall cycles. In the same step it decrements that context's count.

The contexts are loaded by decoded loop-setup commands. Each command carries an operation code, a loop index, a register operand and two unsigned immediates, and it is interpreted relative to the issuing PC. The same six registers can also be written and read through a CSR-style port, so that a debugger or a context switch can save and restore them. Loop 0 is meant for the inner loop: when both contexts end on the same instruction, loop 0 alone advances. The controller does not enforce a minimum body size; software must keep every body at least two instructions long.

Top module: `hwloop_ctrl`

## Requirements
- R1: After reset, all six loop registers read as zero and `jump_o` is low.
- R2: The CSR port maps loop 0 start/end/count to 0x7B0/0x7B1/0x7B2 and loop 1 start/end/count to 0x7B4/0x7B5/0x7B6. All six are read/write, and reads are combinational. Any other address reads as zero, and a write to it changes no register.
- R3: A loop context is active only while its count is nonzero. With both counts zero, no PC produces a jump.
- R4: When `issue_valid_i` is high, `pc_i` equals an active loop's end address and that loop's count is greater than one, `jump_o` is high in the same cycle and `jump_target_o` equals that loop's start address. On the next clock edge the count decrements by one.
- R5: When both loops are active with the same end address and that address is issued, only loop 0 is used: its start is the target, its count decrements, and loop 1's count is unchanged.
- R6: When the matching loop's count is exactly one, no jump is raised and the count becomes zero, so execution falls through.
- R7: Operation 000 sets start and operation 001 sets end, each to PC + (zero-extended 12-bit immediate << 1), in the loop selected by the loop index (0 or 1).
- R8: Operation 010 loads the count from the register operand, and operation 011 loads it from the zero-extended 12-bit immediate.
- R9: Operations 100 and 101 set start to PC + 4 and end to PC + zero-extended 12-bit immediate. Operation 100 takes the count from the register operand, and operation 101 takes it from the zero-extended 5-bit immediate.
- R10: When a setup command and a CSR write hit the same register in one cycle, the setup command's value is stored. Writes to different registers in the same cycle both take effect.
- R11: Operation codes 110 and 111 change no register.
- R12: With `issue_valid_i` low, no jump is raised and no count changes, even when `pc_i` equals an active end address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| issue_valid_i | input | 1 | An instruction is issued at `pc_i` this cycle |
| pc_i | input | 32 | Address of the issuing instruction |
| setup_valid_i | input | 1 | A loop-setup command is issued this cycle |
| setup_op_i | input | 3 | Setup operation code (000 to 101) |
| setup_loop_i | input | 1 | Target loop index |
| setup_rs1_i | input | 32 | Register operand value |
| setup_imm_i | input | 12 | Unsigned 12-bit immediate |
| setup_uimm_i | input | 5 | Unsigned 5-bit immediate |
| csr_we_i | input | 1 | CSR write strobe |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | 32 | CSR write data |
| csr_rdata_o | output | 32 | CSR read data for `csr_addr_i` |
| jump_o | output | 1 | Redirect fetch to `jump_target_o` |
| jump_target_o | output | 32 | Loop start address to fetch from |

## Verification
A PC model walks nested loop pairs over every outer and inner count from 1 to 4. The inner loop is re-armed by a one-shot setup at the top of each outer pass. The number of times the inner end is reached must equal the product of the two counts, which separates a wrong decrement, a missing fall-through or a lost re-arm. A second sweep gives both contexts the same end address with counts from 1 to 3. There, loop 1's count must stay untouched while loop 0 runs out, which separates correct priority from shared or wrong-loop decrementing. Directed cases cover each setup operation, including the largest immediate, as well as the reserved codes, the CSR-versus-setup collision and an end-address match with no issue.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;

    parameter int unsigned HWL_XLEN       = 32;
    parameter int unsigned HWL_NUM_LOOPS  = 2;
    parameter int unsigned HWL_IMM_W      = 12;
    parameter int unsigned HWL_UIMM_W     = 5;
    parameter int unsigned HWL_CSR_W      = 12;
    parameter int unsigned HWL_CSR_STRIDE = 4;
    parameter int unsigned HWL_INSN_BYTES = 4;
    parameter logic [11:0] HWL_CSR_BASE   = 12'h7B0;

    localparam int unsigned HWL_LIDX_W = (HWL_NUM_LOOPS > 1) ? $clog2(HWL_NUM_LOOPS) : 1;

    typedef logic [HWL_XLEN-1:0] word_t;

    typedef enum logic [2:0] {
        OP_START_IMM = 3'b000,
        OP_END_IMM   = 3'b001,
        OP_CNT_REG   = 3'b010,
        OP_CNT_IMM   = 3'b011,
        OP_SETUP_REG = 3'b100,
        OP_SETUP_IMM = 3'b101
    } lp_op_e;

    typedef struct packed {
        word_t [HWL_NUM_LOOPS-1:0] start;
        word_t [HWL_NUM_LOOPS-1:0] lend;
        word_t [HWL_NUM_LOOPS-1:0] cnt;
    } lp_state_t;

endpackage

// File: rtl/hwloop_cmd_dec.sv
module hwloop_cmd_dec
    import hwloop_pkg::*;
(
    input  logic                     valid_i,
    input  logic [2:0]               op_i,
    input  logic [HWL_LIDX_W-1:0]    loop_i,
    input  word_t                    pc_i,
    input  word_t                    rs1_i,
    input  logic [HWL_IMM_W-1:0]     imm_i,
    input  logic [HWL_UIMM_W-1:0]    uimm_i,
    output logic [HWL_NUM_LOOPS-1:0] we_start_o,
    output logic [HWL_NUM_LOOPS-1:0] we_lend_o,
    output logic [HWL_NUM_LOOPS-1:0] we_cnt_o,
    output word_t                    start_o,
    output word_t                    lend_o,
    output word_t                    cnt_o
);

    logic  set_start, set_lend, set_cnt;
    word_t imm_z;

    assign imm_z = word_t'(imm_i);

    always_comb begin
        set_start = 1'b0;
        set_lend  = 1'b0;
        set_cnt   = 1'b0;
        start_o   = pc_i + word_t'(HWL_INSN_BYTES);
        lend_o    = pc_i + imm_z;
        cnt_o     = rs1_i;
        case (lp_op_e'(op_i))
            OP_START_IMM: begin
                set_start = 1'b1;
                start_o   = pc_i + (imm_z << 1);
            end
            OP_END_IMM: begin
                set_lend = 1'b1;
                lend_o   = pc_i + (imm_z << 1);
            end
            OP_CNT_REG: set_cnt = 1'b1;
            OP_CNT_IMM: begin
                set_cnt = 1'b1;
                cnt_o   = imm_z;
            end
            OP_SETUP_REG: begin
                set_start = 1'b1;
                set_lend  = 1'b1;
                set_cnt   = 1'b1;
            end
            OP_SETUP_IMM: begin
                set_start = 1'b1;
                set_lend  = 1'b1;
                set_cnt   = 1'b1;
                cnt_o     = word_t'(uimm_i);
            end
            default: ;
        endcase
    end

    for (genvar i = 0; i < HWL_NUM_LOOPS; i++) begin : g_loop
        logic hit;
        assign hit           = valid_i && (loop_i == HWL_LIDX_W'(i));
        assign we_start_o[i] = hit && set_start;
        assign we_lend_o[i]  = hit && set_lend;
        assign we_cnt_o[i]   = hit && set_cnt;
    end

endmodule

// File: rtl/hwloop_csr_map.sv
module hwloop_csr_map
    import hwloop_pkg::*;
(
    input  logic                      we_i,
    input  logic [HWL_CSR_W-1:0]      addr_i,
    input  word_t [HWL_NUM_LOOPS-1:0] start_i,
    input  word_t [HWL_NUM_LOOPS-1:0] lend_i,
    input  word_t [HWL_NUM_LOOPS-1:0] cnt_i,
    output logic [HWL_NUM_LOOPS-1:0]  we_start_o,
    output logic [HWL_NUM_LOOPS-1:0]  we_lend_o,
    output logic [HWL_NUM_LOOPS-1:0]  we_cnt_o,
    output word_t                     rdata_o
);

    word_t [HWL_NUM_LOOPS-1:0] part;

    for (genvar i = 0; i < HWL_NUM_LOOPS; i++) begin : g_loop
        localparam logic [HWL_CSR_W-1:0] BASE = HWL_CSR_BASE + HWL_CSR_W'(HWL_CSR_STRIDE * i);
        logic sel_s, sel_e, sel_c;
        assign sel_s = (addr_i == BASE);
        assign sel_e = (addr_i == BASE + HWL_CSR_W'(1));
        assign sel_c = (addr_i == BASE + HWL_CSR_W'(2));
        assign we_start_o[i] = we_i && sel_s;
        assign we_lend_o[i]  = we_i && sel_e;
        assign we_cnt_o[i]   = we_i && sel_c;
        assign part[i] = ({HWL_XLEN{sel_s}} & start_i[i])
                       | ({HWL_XLEN{sel_e}} & lend_i[i])
                       | ({HWL_XLEN{sel_c}} & cnt_i[i]);
    end

    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < HWL_NUM_LOOPS; i++) begin
            rdata_o = rdata_o | part[i];
        end
    end

endmodule

// File: rtl/hwloop_match.sv
module hwloop_match
    import hwloop_pkg::*;
(
    input  logic                      valid_i,
    input  word_t                     pc_i,
    input  word_t [HWL_NUM_LOOPS-1:0] lend_i,
    input  word_t [HWL_NUM_LOOPS-1:0] cnt_i,
    output logic                      hit_o,
    output logic [HWL_LIDX_W-1:0]     sel_o,
    output logic                      jump_o
);

    logic [HWL_NUM_LOOPS-1:0] hit;

    for (genvar i = 0; i < HWL_NUM_LOOPS; i++) begin : g_cmp
        assign hit[i] = valid_i && (cnt_i[i] != '0) && (pc_i == lend_i[i]);
    end

    // lowest index wins: scan from the top so index 0 is applied last
    always_comb begin
        sel_o = '0;
        for (int i = HWL_NUM_LOOPS - 1; i >= 0; i--) begin
            if (hit[i]) sel_o = HWL_LIDX_W'(i);
        end
    end

    assign hit_o  = |hit;
    assign jump_o = hit_o && (cnt_i[sel_o] > word_t'(1));

endmodule

// File: rtl/hwloop_ctrl.sv
module hwloop_ctrl
    import hwloop_pkg::*;
(
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  issue_valid_i,
    input  logic [HWL_XLEN-1:0]   pc_i,
    input  logic                  setup_valid_i,
    input  logic [2:0]            setup_op_i,
    input  logic [HWL_LIDX_W-1:0] setup_loop_i,
    input  logic [HWL_XLEN-1:0]   setup_rs1_i,
    input  logic [HWL_IMM_W-1:0]  setup_imm_i,
    input  logic [HWL_UIMM_W-1:0] setup_uimm_i,
    input  logic                  csr_we_i,
    input  logic [HWL_CSR_W-1:0]  csr_addr_i,
    input  logic [HWL_XLEN-1:0]   csr_wdata_i,
    output logic [HWL_XLEN-1:0]   csr_rdata_o,
    output logic                  jump_o,
    output logic [HWL_XLEN-1:0]   jump_target_o
);

    lp_state_t state_d, state_q;

    logic [HWL_NUM_LOOPS-1:0] cmd_we_start, cmd_we_lend, cmd_we_cnt;
    logic [HWL_NUM_LOOPS-1:0] csr_we_start, csr_we_lend, csr_we_cnt;
    word_t                    cmd_start, cmd_lend, cmd_cnt;
    logic                     m_hit, m_jump;
    logic [HWL_LIDX_W-1:0]    m_sel;

    hwloop_cmd_dec u_dec (
        .valid_i    (setup_valid_i),
        .op_i       (setup_op_i),
        .loop_i     (setup_loop_i),
        .pc_i       (pc_i),
        .rs1_i      (setup_rs1_i),
        .imm_i      (setup_imm_i),
        .uimm_i     (setup_uimm_i),
        .we_start_o (cmd_we_start),
        .we_lend_o  (cmd_we_lend),
        .we_cnt_o   (cmd_we_cnt),
        .start_o    (cmd_start),
        .lend_o     (cmd_lend),
        .cnt_o      (cmd_cnt)
    );

    hwloop_csr_map u_csr (
        .we_i       (csr_we_i),
        .addr_i     (csr_addr_i),
        .start_i    (state_q.start),
        .lend_i     (state_q.lend),
        .cnt_i      (state_q.cnt),
        .we_start_o (csr_we_start),
        .we_lend_o  (csr_we_lend),
        .we_cnt_o   (csr_we_cnt),
        .rdata_o    (csr_rdata_o)
    );

    hwloop_match u_match (
        .valid_i (issue_valid_i),
        .pc_i    (pc_i),
        .lend_i  (state_q.lend),
        .cnt_i   (state_q.cnt),
        .hit_o   (m_hit),
        .sel_o   (m_sel),
        .jump_o  (m_jump)
    );

    // update order: loop-end decrement, then CSR write, then setup command
    always_comb begin
        state_d = state_q;
        for (int i = 0; i < HWL_NUM_LOOPS; i++) begin
            if (m_hit && (m_sel == HWL_LIDX_W'(i))) state_d.cnt[i] = state_q.cnt[i] - word_t'(1);
            if (csr_we_start[i]) state_d.start[i] = csr_wdata_i;
            if (csr_we_lend[i])  state_d.lend[i]  = csr_wdata_i;
            if (csr_we_cnt[i])   state_d.cnt[i]   = csr_wdata_i;
            if (cmd_we_start[i]) state_d.start[i] = cmd_start;
            if (cmd_we_lend[i])  state_d.lend[i]  = cmd_lend;
            if (cmd_we_cnt[i])   state_d.cnt[i]   = cmd_cnt;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= '0;
        else         state_q <= state_d;
    end

    assign jump_o        = m_jump;
    assign jump_target_o = state_q.start[m_sel];

endmodule

// File: rtl/hwloop_ctrl_chk.sv
module hwloop_ctrl_chk
    import hwloop_pkg::*;
(
    input logic        clk_i,
    input logic        rst_ni,
    input logic        issue_valid_i,
    input word_t       pc_i,
    input logic        setup_valid_i,
    input logic        csr_we_i,
    input logic        jump_o,
    input word_t       jump_target_o,
    input word_t [1:0] start_q,
    input word_t [1:0] lend_q,
    input word_t [1:0] cnt_q
);

    logic quiet;
    assign quiet = !setup_valid_i && !csr_we_i;

    assert_inactive_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_q[0] == '0 && cnt_q[1] == '0) |-> !jump_o);

    assert_jump_target_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        jump_o |-> ((jump_target_o == start_q[0] && pc_i == lend_q[0] && cnt_q[0] > 1)
                 || (jump_target_o == start_q[1] && pc_i == lend_q[1] && cnt_q[1] > 1
                     && !(pc_i == lend_q[0] && cnt_q[0] != '0))));

    assert_decrement_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (issue_valid_i && quiet && pc_i == lend_q[0] && cnt_q[0] > 1)
        |=> (cnt_q[0] == $past(cnt_q[0]) - 1));

    assert_same_end_prio_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (issue_valid_i && quiet && cnt_q[0] != '0 && cnt_q[1] != '0
         && pc_i == lend_q[0] && lend_q[0] == lend_q[1]) |=> $stable(cnt_q[1]));

    assert_last_iter_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (issue_valid_i && pc_i == lend_q[0] && cnt_q[0] == 1) |-> !jump_o);

    assert_last_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (issue_valid_i && quiet && pc_i == lend_q[0] && cnt_q[0] == 1) |=> (cnt_q[0] == '0));

    assert_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !issue_valid_i |-> !jump_o);

endmodule

bind hwloop_ctrl hwloop_ctrl_chk u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .issue_valid_i (issue_valid_i),
    .pc_i          (pc_i),
    .setup_valid_i (setup_valid_i),
    .csr_we_i      (csr_we_i),
    .jump_o        (jump_o),
    .jump_target_o (jump_target_o),
    .start_q       (state_q.start),
    .lend_q        (state_q.lend),
    .cnt_q         (state_q.cnt)
);

// File: tb/hwloop_ctrl_test.sv
module hwloop_ctrl_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic        issue_valid_i = 1'b0;
    logic [31:0] pc_i = '0;
    logic        setup_valid_i = 1'b0;
    logic [2:0]  setup_op_i = '0;
    logic [0:0]  setup_loop_i = '0;
    logic [31:0] setup_rs1_i = '0;
    logic [11:0] setup_imm_i = '0;
    logic [4:0]  setup_uimm_i = '0;
    logic        csr_we_i = 1'b0;
    logic [11:0] csr_addr_i = '0;
    logic [31:0] csr_wdata_i = '0;
    logic [31:0] csr_rdata_o;
    logic        jump_o;
    logic [31:0] jump_target_o;

    int n_chk = 0;
    int n_err = 0;

    logic [31:0] m_start [2];
    logic [31:0] m_lend  [2];
    logic [31:0] m_cnt   [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    hwloop_ctrl uut (
        .clk_i         (clk),
        .rst_ni        (rst_ni),
        .issue_valid_i (issue_valid_i),
        .pc_i          (pc_i),
        .setup_valid_i (setup_valid_i),
        .setup_op_i    (setup_op_i),
        .setup_loop_i  (setup_loop_i),
        .setup_rs1_i   (setup_rs1_i),
        .setup_imm_i   (setup_imm_i),
        .setup_uimm_i  (setup_uimm_i),
        .csr_we_i      (csr_we_i),
        .csr_addr_i    (csr_addr_i),
        .csr_wdata_i   (csr_wdata_i),
        .csr_rdata_o   (csr_rdata_o),
        .jump_o        (jump_o),
        .jump_target_o (jump_target_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic csr_rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        csr_addr_i = a;
        #1;
        check(tag, csr_rdata_o, exp);
    endtask

    // one clock of stimulus; checks the combinational jump, then updates the model
    task automatic cycle(input logic iv, input logic [31:0] pc,
                         input logic sv, input logic [2:0] op, input logic idx,
                         input logic [31:0] rs1, input logic [11:0] i12, input logic [4:0] u5,
                         input logic cw, input logic [11:0] ca, input logic [31:0] cd,
                         output logic ej, output logic [31:0] et);
        logic m0, m1;
        int   s;
        logic [31:0] iz;
        issue_valid_i = iv; pc_i = pc;
        setup_valid_i = sv; setup_op_i = op; setup_loop_i = idx;
        setup_rs1_i = rs1; setup_imm_i = i12; setup_uimm_i = u5;
        csr_we_i = cw; csr_addr_i = ca; csr_wdata_i = cd;
        #1;
        m0 = iv && m_cnt[0] != 0 && pc == m_lend[0];
        m1 = iv && m_cnt[1] != 0 && pc == m_lend[1];
        s  = m0 ? 0 : 1;
        ej = (m0 || m1) && m_cnt[s] > 1;
        et = m_start[s];
        check("R4/R6 jump flag", {31'b0, jump_o}, {31'b0, ej});
        if (ej) check("R4/R5 jump target", jump_target_o, et);
        @(posedge clk);
        if (m0 || m1) m_cnt[s] = m_cnt[s] - 1;
        if (cw) begin
            case (ca)
                12'h7B0: m_start[0] = cd;
                12'h7B1: m_lend[0]  = cd;
                12'h7B2: m_cnt[0]   = cd;
                12'h7B4: m_start[1] = cd;
                12'h7B5: m_lend[1]  = cd;
                12'h7B6: m_cnt[1]   = cd;
                default: ;
            endcase
        end
        if (sv) begin
            iz = {20'b0, i12};
            case (op)
                3'b000: m_start[idx] = pc + (iz << 1);
                3'b001: m_lend[idx]  = pc + (iz << 1);
                3'b010: m_cnt[idx]   = rs1;
                3'b011: m_cnt[idx]   = iz;
                3'b100: begin m_start[idx] = pc + 4; m_lend[idx] = pc + iz; m_cnt[idx] = rs1; end
                3'b101: begin m_start[idx] = pc + 4; m_lend[idx] = pc + iz; m_cnt[idx] = {27'b0, u5}; end
                default: ;
            endcase
        end
        @(negedge clk);
        issue_valid_i = 1'b0; setup_valid_i = 1'b0; csr_we_i = 1'b0;
    endtask

    task automatic csr_wr(input logic [11:0] a, input logic [31:0] d);
        logic j; logic [31:0] t;
        cycle(0, 32'h0, 0, 3'b0, 0, 32'h0, 12'h0, 5'h0, 1, a, d, j, t);
    endtask

    task automatic setup(input logic [31:0] pc, input logic [2:0] op, input logic idx,
                         input logic [31:0] rs1, input logic [11:0] i12, input logic [4:0] u5);
        logic j; logic [31:0] t;
        cycle(0, pc, 1, op, idx, rs1, i12, u5, 0, 12'h0, 32'h0, j, t);
    endtask

    task automatic issue(input logic [31:0] pc, output logic j, output logic [31:0] t);
        cycle(1, pc, 0, 3'b0, 0, 32'h0, 12'h0, 5'h0, 0, 12'h0, 32'h0, j, t);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        logic j;
        logic [31:0] t;
        logic [31:0] pc;
        int visits, steps;
        for (int i = 0; i < 2; i++) begin m_start[i] = 0; m_lend[i] = 0; m_cnt[i] = 0; end
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 jump low in reset", {31'b0, jump_o}, 32'h0);
        rst_ni = 1'b1;
        #1;
        // R1 reset values
        csr_rd(12'h7B0, 0, "R1 start0"); csr_rd(12'h7B1, 0, "R1 end0"); csr_rd(12'h7B2, 0, "R1 cnt0");
        csr_rd(12'h7B4, 0, "R1 start1"); csr_rd(12'h7B5, 0, "R1 end1"); csr_rd(12'h7B6, 0, "R1 cnt1");
        check("R1 jump low", {31'b0, jump_o}, 32'h0);
        @(negedge clk);

        // R2 CSR map round trip
        csr_wr(12'h7B0, 32'h1111_0000); csr_wr(12'h7B1, 32'h2222_0000); csr_wr(12'h7B2, 32'h0);
        csr_wr(12'h7B4, 32'h4444_0000); csr_wr(12'h7B5, 32'h5555_0000); csr_wr(12'h7B6, 32'h0);
        csr_wr(12'h7B3, 32'hFFFF_FFFF);
        csr_rd(12'h7B0, 32'h1111_0000, "R2 start0"); csr_rd(12'h7B1, 32'h2222_0000, "R2 end0");
        csr_rd(12'h7B4, 32'h4444_0000, "R2 start1"); csr_rd(12'h7B5, 32'h5555_0000, "R2 end1");
        csr_rd(12'h7B2, 0, "R2 cnt0 after unmapped write"); csr_rd(12'h7B6, 0, "R2 cnt1 after unmapped write");
        csr_rd(12'h7B3, 0, "R2 unmapped read");
        @(negedge clk);

        // R7 immediate start/end
        setup(32'h1000, 3'b000, 1, 0, 12'hFFF, 0);
        csr_rd(12'h7B4, 32'h0000_2FFE, "R7 start1 max imm");
        setup(32'h0040, 3'b001, 0, 0, 12'h010, 0);
        csr_rd(12'h7B1, 32'h0000_0060, "R7 end0");
        csr_rd(12'h7B5, 32'h5555_0000, "R7 end1 untouched");
        @(negedge clk);

        // R8 count loads
        setup(32'h0, 3'b010, 0, 32'hDEAD_BEEF, 12'h0, 0);
        csr_rd(12'h7B2, 32'hDEAD_BEEF, "R8 cnt0 from register");
        setup(32'h0, 3'b011, 1, 32'hFFFF_FFFF, 12'hABC, 5'h1F);
        csr_rd(12'h7B6, 32'h0000_0ABC, "R8 cnt1 from imm");
        @(negedge clk);

        // R11 reserved codes
        setup(32'h0800, 3'b110, 0, 32'h1234, 12'h123, 5'h3);
        setup(32'h0800, 3'b111, 0, 32'h1234, 12'h123, 5'h3);
        csr_rd(12'h7B0, 32'h1111_0000, "R11 start0"); csr_rd(12'h7B1, 32'h0000_0060, "R11 end0");
        csr_rd(12'h7B2, 32'hDEAD_BEEF, "R11 cnt0");
        @(negedge clk);

        // R10 collision, then different registers in one cycle
        cycle(0, 32'h0, 1, 3'b011, 0, 0, 12'h007, 0, 1, 12'h7B2, 32'h5, j, t);
        csr_rd(12'h7B2, 32'h7, "R10 setup wins on cnt0");
        cycle(0, 32'h0, 1, 3'b011, 0, 0, 12'h009, 0, 1, 12'h7B0, 32'h50, j, t);
        csr_rd(12'h7B2, 32'h9, "R10 cnt0 via setup"); csr_rd(12'h7B0, 32'h50, "R10 start0 via csr");
        @(negedge clk);

        // R3 inactive loops
        csr_wr(12'h7B2, 0); csr_wr(12'h7B6, 0);
        issue(32'h60, j, t);
        check("R3 no jump at end with zero count", {31'b0, j}, 0);

        // R12 no issue
        csr_wr(12'h7B2, 3);
        cycle(0, 32'h60, 0, 3'b0, 0, 0, 0, 0, 0, 12'h0, 0, j, t);
        csr_rd(12'h7B2, 3, "R12 count held without issue");
        @(negedge clk);

        // R4 then R6
        issue(32'h60, j, t); check("R4 first jump", {31'b0, j}, 1);
        csr_rd(12'h7B2, 2, "R4 decrement"); @(negedge clk);
        issue(32'h60, j, t); check("R4 second jump", {31'b0, j}, 1);
        issue(32'h60, j, t); check("R6 fall through", {31'b0, j}, 0);
        csr_rd(12'h7B2, 0, "R6 count cleared");
        @(negedge clk);

        // R9 nested sweep with one-shot setups
        for (int nout = 1; nout <= 4; nout++) begin
            for (int nin = 1; nin <= 4; nin++) begin
                setup(32'h0FC, 3'b100, 1, nout, 12'h014, 0);
                if (nout == 1 && nin == 1) begin
                    csr_rd(12'h7B4, 32'h100, "R9 start1 = pc+4");
                    csr_rd(12'h7B5, 32'h110, "R9 end1 = pc+imm");
                    csr_rd(12'h7B6, 32'h1, "R9 count from register");
                    @(negedge clk);
                end
                pc = 32'h100; visits = 0; steps = 0;
                while (pc <= 32'h110 && steps < 500) begin
                    if (pc == 32'h100)
                        cycle(1, pc, 1, 3'b101, 0, 0, 12'h008, 5'(nin), 0, 12'h0, 0, j, t);
                    else
                        issue(pc, j, t);
                    if (pc == 32'h108) visits++;
                    pc = j ? t : pc + 4;
                    steps++;
                end
                check("R9 inner body end visits", visits, nout * nin);
                csr_rd(12'h7B2, 0, "R9 final cnt0");
                csr_rd(12'h7B6, 0, "R9 final cnt1");
                @(negedge clk);
            end
        end

        // R5 same-end sweep
        for (int c0 = 1; c0 <= 3; c0++) begin
            for (int c1 = 1; c1 <= 3; c1++) begin
                csr_wr(12'h7B0, 32'h204); csr_wr(12'h7B1, 32'h20C); csr_wr(12'h7B2, c0);
                csr_wr(12'h7B4, 32'h200); csr_wr(12'h7B5, 32'h20C); csr_wr(12'h7B6, c1);
                pc = 32'h200; visits = 0; steps = 0;
                while (pc <= 32'h20C && steps < 200) begin
                    issue(pc, j, t);
                    if (pc == 32'h20C) visits++;
                    pc = j ? t : pc + 4;
                    steps++;
                end
                check("R5 shared end visits", visits, c0);
                csr_rd(12'h7B2, 0, "R5 loop0 exhausted");
                csr_rd(12'h7B6, c1, "R5 loop1 untouched");
                @(negedge clk);
            end
        end

        summary();
        $finish;
    end

endmodule